// File: doc/BRIEF.md
# ATM Cell Error Injector and Loopback Router

This block sits between the upstream cell interface and the line side of an ATM physical-layer device. It handles two byte streams: the transmit stream from the upstream device, heading for the line, and the receive stream from the line, heading for the receive cell buffer. Each stream carries a valid strobe and a start-of-cell marker.

For test purposes the block can corrupt outgoing cells. It can invert the low bit of the header check byte (cell byte 5), of the final payload byte (cell byte 53), or of both. The block samples each corruption control at the cell's start-of-cell byte and holds it for that whole cell.

A two-bit loopback selector picks how the streams are routed:
- **Normal (00) and the reserved code (01):** the transmit stream goes to the line and the line stream goes to the cell buffer.
- **PHY loopback (10):** the corrupted transmit stream feeds the cell buffer and also stays on the line.
- **Line loopback (11):** the received line stream is sent back out to the line and also feeds the cell buffer.

A separate control forces the outgoing cell-available flag low, so the upstream device stops sending while a loopback is active.

The transmit path contains a two-state machine:
- **IDLE** is entered at reset and after byte 53 of a cell. Bytes that arrive in IDLE without a start-of-cell marker pass through untouched.
- **CELL** is entered on any valid start-of-cell byte, from either state. That byte is counted as byte 1 and the two corruption controls are latched. The state stays in CELL while valid bytes 2 to 52 arrive. A valid byte reaching count 53 takes it back to IDLE. A start-of-cell byte that arrives mid-cell restarts the count.

Both data paths have exactly one register stage. The loopback selector and the flag gating act combinationally on the outputs.

Top module: `atm_err_lpbk`

## Requirements
- R1: While reset is held and at the first sample after it, line_tx_valid_o and cell_rx_valid_o are 0.
- R2: When hec_err_i is 1 at a cell's start-of-cell byte, bit 0 of that cell's byte 5 (start-of-cell byte = byte 1) leaves inverted, and bits 7:1 are unchanged.
- R3: When pay_err_i is 1 at a cell's start-of-cell byte, bit 0 of that cell's byte 53 leaves inverted, and bits 7:1 are unchanged.
- R4: A change of hec_err_i or pay_err_i after a cell's start-of-cell byte has no effect on that cell's bytes.
- R5: Every other transmit byte, and every byte outside a cell, is forwarded unchanged one clock after it is accepted, with its start-of-cell marker. Bytes with valid low are not counted.
- R6: With loop_sel_i = 00 or 01, the line output carries the transmit path and the cell-buffer output carries the line input delayed one clock.
- R7: With loop_sel_i = 10, both the cell-buffer output and the line output carry the processed transmit path.
- R8: With loop_sel_i = 11, both the line output and the cell-buffer output carry the line input delayed one clock.
- R9: tx_clav_o equals tx_clav_i AND NOT clav_block_i, in the same cycle.
- R10: A start-of-cell byte arriving mid-cell restarts the byte count at 1 and relatches both corruption controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid_i | input | 1 | Upstream transmit byte valid |
| tx_soc_i | input | 1 | Upstream start-of-cell marker |
| tx_data_i | input | 8 | Upstream transmit byte |
| rx_valid_i | input | 1 | Line receive byte valid |
| rx_soc_i | input | 1 | Line receive start-of-cell marker |
| rx_data_i | input | 8 | Line receive byte |
| hec_err_i | input | 1 | Corrupt byte 5 of cells starting while high |
| pay_err_i | input | 1 | Corrupt byte 53 of cells starting while high |
| loop_sel_i | input | 2 | Loopback selector (00 normal, 01 reserved, 10 PHY, 11 line) |
| clav_block_i | input | 1 | Force cell-available flag low |
| tx_clav_i | input | 1 | Cell-available flag from transmit buffer |
| tx_clav_o | output | 1 | Gated cell-available flag to upstream |
| line_tx_valid_o | output | 1 | Line transmit byte valid |
| line_tx_soc_o | output | 1 | Line transmit start-of-cell |
| line_tx_data_o | output | 8 | Line transmit byte |
| cell_rx_valid_o | output | 1 | Cell-buffer byte valid |
| cell_rx_soc_o | output | 1 | Cell-buffer start-of-cell |
| cell_rx_data_o | output | 8 | Cell-buffer byte |

## Verification
The bench targets the following corner cases, each of which exposes a specific class of bug:

- **Control toggles mid-cell.** A design that sampled the controls live instead of at start-of-cell would corrupt or spare the wrong cells.
- **Valid gaps inside a cell.** A counter that advanced on idle cycles would hit the wrong byte.
- **Short cells restarted by an early start-of-cell.** A design that ignored the restart would flip a byte of the next cell.
- **All four loopback codes, including the reserved one.** A decode slip would send line data to the wrong output or treat code 01 as a loopback.

The bench also drives the flag gate with every input pair, so an inverted or registered gate shows up at once.

// File: rtl/atm_lpbk_pkg.sv
package atm_lpbk_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        LB_NORMAL = 2'b00,
        LB_RSVD   = 2'b01,
        LB_PHY    = 2'b10,
        LB_LINE   = 2'b11
    } lb_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CELL = 1'b1
    } cell_st_e;

    typedef struct packed {
        logic              valid;
        logic              soc;
        logic [BYTE_W-1:0] data;
    } lane_t;

endpackage

// File: rtl/atm_err_inject.sv
module atm_err_inject
    import atm_lpbk_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int HEC_POS    = 5,
    parameter int FLIP_BIT   = 0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  lane_t in_i,
    input  logic  hec_en_i,
    input  logic  pay_en_i,
    output lane_t out_o
);

    localparam int                CNT_W    = $clog2(CELL_BYTES + 1);
    localparam logic [CNT_W-1:0]  LAST_IDX = CNT_W'(CELL_BYTES);
    localparam logic [CNT_W-1:0]  HEC_IDX  = CNT_W'(HEC_POS);
    localparam logic [BYTE_W-1:0] FLIP_MSK = BYTE_W'(1) << FLIP_BIT;

    cell_st_e         state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             hec_q, hec_d, pay_q, pay_d;
    logic             flip;
    logic             past_ok;

    // next-state and byte position decode
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hec_d   = hec_q;
        pay_d   = pay_q;
        flip    = 1'b0;
        if (in_i.valid) begin
            if (in_i.soc) begin
                state_d = ST_CELL;
                cnt_d   = CNT_W'(1);
                hec_d   = hec_en_i;
                pay_d   = pay_en_i;
            end else begin
                unique case (state_q)
                    ST_IDLE: ;
                    ST_CELL: begin
                        cnt_d = cnt_q + CNT_W'(1);
                        flip  = ((cnt_d == HEC_IDX) && hec_q) ||
                                ((cnt_d == LAST_IDX) && pay_q);
                        if (cnt_d == LAST_IDX) begin
                            state_d = ST_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            hec_q   <= 1'b0;
            pay_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            hec_q   <= hec_d;
            pay_q   <= pay_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_o <= '0;
        end else begin
            out_o.valid <= in_i.valid;
            out_o.soc   <= in_i.valid & in_i.soc;
            out_o.data  <= in_i.data ^ (flip ? FLIP_MSK : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CELL) |-> (cnt_q >= CNT_W'(1) && cnt_q < LAST_IDX));

    assert_upper_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(in_i.valid)) |->
            (out_o.data[BYTE_W-1:1] == $past(in_i.data[BYTE_W-1:1])));

    assert_idle_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(in_i.valid && state_q == ST_IDLE)) |->
            (out_o.data == $past(in_i.data)));

endmodule

// File: rtl/atm_lpbk_mux.sv
module atm_lpbk_mux
    import atm_lpbk_pkg::*;
(
    input  lb_mode_e mode_i,
    input  lane_t    tx_i,
    input  lane_t    rx_i,
    output lane_t    line_o,
    output lane_t    cell_o
);

    always_comb begin
        unique case (mode_i)
            LB_NORMAL, LB_RSVD: begin
                line_o = tx_i;
                cell_o = rx_i;
            end
            LB_PHY: begin
                line_o = tx_i;
                cell_o = tx_i;
            end
            LB_LINE: begin
                line_o = rx_i;
                cell_o = rx_i;
            end
            default: begin
                line_o = tx_i;
                cell_o = rx_i;
            end
        endcase
    end

endmodule

// File: rtl/atm_err_lpbk.sv
module atm_err_lpbk
    import atm_lpbk_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int HEC_POS    = 5,
    parameter int FLIP_BIT   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid_i,
    input  logic              tx_soc_i,
    input  logic [BYTE_W-1:0] tx_data_i,
    input  logic              rx_valid_i,
    input  logic              rx_soc_i,
    input  logic [BYTE_W-1:0] rx_data_i,
    input  logic              hec_err_i,
    input  logic              pay_err_i,
    input  logic [1:0]        loop_sel_i,
    input  logic              clav_block_i,
    input  logic              tx_clav_i,
    output logic              tx_clav_o,
    output logic              line_tx_valid_o,
    output logic              line_tx_soc_o,
    output logic [BYTE_W-1:0] line_tx_data_o,
    output logic              cell_rx_valid_o,
    output logic              cell_rx_soc_o,
    output logic [BYTE_W-1:0] cell_rx_data_o
);

    lane_t tx_in, tx_proc, rx_dly, line_l, cell_l;
    logic  past_ok;

    assign tx_in = '{valid: tx_valid_i, soc: tx_soc_i, data: tx_data_i};

    atm_err_inject #(
        .CELL_BYTES (CELL_BYTES),
        .HEC_POS    (HEC_POS),
        .FLIP_BIT   (FLIP_BIT)
    ) u_inject (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_i     (tx_in),
        .hec_en_i (hec_err_i),
        .pay_en_i (pay_err_i),
        .out_o    (tx_proc)
    );

    // receive stage matches the transmit latency
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_dly <= '0;
        end else begin
            rx_dly.valid <= rx_valid_i;
            rx_dly.soc   <= rx_valid_i & rx_soc_i;
            rx_dly.data  <= rx_data_i;
        end
    end

    atm_lpbk_mux u_mux (
        .mode_i (lb_mode_e'(loop_sel_i)),
        .tx_i   (tx_proc),
        .rx_i   (rx_dly),
        .line_o (line_l),
        .cell_o (cell_l)
    );

    assign line_tx_valid_o = line_l.valid;
    assign line_tx_soc_o   = line_l.soc;
    assign line_tx_data_o  = line_l.data;
    assign cell_rx_valid_o = cell_l.valid;
    assign cell_rx_soc_o   = cell_l.soc;
    assign cell_rx_data_o  = cell_l.data;

    assign tx_clav_o = tx_clav_i & ~clav_block_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_clav_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clav_block_i |-> !tx_clav_o);

    assert_line_lpbk_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && loop_sel_i == 2'b11 && $past(rx_valid_i)) |->
            (line_tx_valid_o && line_tx_data_o == $past(rx_data_i)));

    assert_phy_lpbk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_sel_i == 2'b10) |->
            (cell_rx_valid_o == line_tx_valid_o && cell_rx_data_o == line_tx_data_o));

    assert_normal_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && loop_sel_i[1] == 1'b0 && $past(rx_valid_i)) |->
            (cell_rx_valid_o && cell_rx_data_o == $past(rx_data_i)));

endmodule

// File: tb/tb_atm_err_lpbk.sv
`timescale 1ns/1ps
module tb_atm_err_lpbk;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_valid_i = 0, tx_soc_i = 0, rx_valid_i = 0, rx_soc_i = 0;
    logic [7:0] tx_data_i = 0, rx_data_i = 0;
    logic       hec_err_i = 0, pay_err_i = 0, clav_block_i = 0, tx_clav_i = 0;
    logic [1:0] loop_sel_i = 0;
    logic       tx_clav_o, line_tx_valid_o, line_tx_soc_o, cell_rx_valid_o, cell_rx_soc_o;
    logic [7:0] line_tx_data_o, cell_rx_data_o;

    atm_err_lpbk dut (.*);

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // bench reference state
    int  m_cnt = 0;
    bit  m_in = 0, m_hl = 0, m_pl = 0;
    bit  have_exp = 0;
    bit  e_tv, e_ts, e_rv, e_rs;
    logic [7:0] e_td, e_rd;
    string e_tag;
    int  tx_pos = 0, rx_pos = 0;
    logic [7:0] dir_byte;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string line_tag(input logic [1:0] lp);
        if (lp == 2'b11) return "R8";
        if (lp == 2'b10) return "R7";
        return "R6";
    endfunction

    // compute expected tx byte from requirements R2..R5, R10
    task automatic model_tx();
        e_tag = "R5";
        e_td  = tx_data_i;
        if (tx_valid_i) begin
            if (tx_soc_i) begin
                if (m_in && m_cnt < 53) e_tag = "R10";
                m_cnt = 1; m_in = 1; m_hl = hec_err_i; m_pl = pay_err_i;
            end else if (m_in) begin
                m_cnt++;
                if (m_cnt == 5 && m_hl) begin e_td[0] = ~e_td[0]; e_tag = "R2"; end
                if (m_cnt == 53 && m_pl) begin e_td[0] = ~e_td[0]; e_tag = "R3"; end
                if ((m_cnt == 5 && m_hl != hec_err_i) || (m_cnt == 53 && m_pl != pay_err_i))
                    e_tag = "R4";
                if (m_cnt == 53) m_in = 0;
            end
        end
        e_tv = tx_valid_i; e_ts = tx_valid_i & tx_soc_i;
        e_rv = rx_valid_i; e_rs = rx_valid_i & rx_soc_i; e_rd = rx_data_i;
    endtask

    task automatic check_outputs();
        bit lv, ls, cv, cs;
        logic [7:0] ld, cd;
        lv = (loop_sel_i == 2'b11) ? e_rv : e_tv;
        ls = (loop_sel_i == 2'b11) ? e_rs : e_ts;
        ld = (loop_sel_i == 2'b11) ? e_rd : e_td;
        cv = (loop_sel_i == 2'b10) ? e_tv : e_rv;
        cs = (loop_sel_i == 2'b10) ? e_ts : e_rs;
        cd = (loop_sel_i == 2'b10) ? e_td : e_rd;
        chk({line_tag(loop_sel_i), " line valid"}, line_tx_valid_o, lv);
        chk({line_tag(loop_sel_i), " cell valid"}, cell_rx_valid_o, cv);
        if (lv) begin
            chk({(loop_sel_i == 2'b11) ? "R8" : e_tag, " line byte"}, line_tx_data_o, ld);
            chk({line_tag(loop_sel_i), " line soc"}, line_tx_soc_o, ls);
        end
        if (cv) begin
            chk({(loop_sel_i == 2'b10) ? e_tag : line_tag(loop_sel_i), " cell byte"}, cell_rx_data_o, cd);
            chk({line_tag(loop_sel_i), " cell soc"}, cell_rx_soc_o, cs);
        end
    endtask

    // one cycle: check last cycle's result, then apply the new inputs
    task automatic cycle();
        @(negedge clk);
        if (have_exp) check_outputs();
    endtask

    task automatic apply();
        model_tx();
        have_exp = 1;
        #1;
        chk("R9 clav gate", tx_clav_o, tx_clav_i & ~clav_block_i);
    endtask

    task automatic gen_tx(input bit allow_short);
        tx_valid_i = ($urandom_range(0, 9) != 0);
        tx_data_i  = 8'($urandom);
        tx_soc_i   = 0;
        if (tx_valid_i) begin
            if (tx_pos == 0 || (allow_short && $urandom_range(0, 150) == 0)) begin
                tx_soc_i = 1; tx_pos = 1;
            end else begin
                tx_pos = (tx_pos >= 53 + $urandom_range(0, 2)) ? 0 : tx_pos + 1;
                if (tx_pos == 0) begin tx_soc_i = 1; tx_pos = 1; end
            end
        end
    endtask

    task automatic gen_rx();
        rx_valid_i = ($urandom_range(0, 7) != 0);
        rx_data_i  = 8'($urandom);
        rx_soc_i   = 0;
        if (rx_valid_i) begin
            rx_pos = (rx_pos >= 53) ? 1 : rx_pos + 1;
            rx_soc_i = (rx_pos == 1);
        end
    endtask

    initial begin
        void'($urandom(32'd20241));
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 line valid in reset", line_tx_valid_o, 1'b0);
        chk("R1 cell valid in reset", cell_rx_valid_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 line valid after reset", line_tx_valid_o, 1'b0);
        chk("R1 cell valid after reset", cell_rx_valid_o, 1'b0);

        // directed: four cells, control patterns across loop codes 00 and 10
        for (int c = 0; c < 4; c++) begin
            for (int b = 1; b <= 53; b++) begin
                cycle();
                loop_sel_i = (c >= 2) ? 2'b10 : 2'b00;
                tx_valid_i = 1; tx_soc_i = (b == 1);
                dir_byte = 8'(b * 3 + c);
                tx_data_i = dir_byte;
                rx_valid_i = 1; rx_soc_i = (b == 1); rx_data_i = ~dir_byte;
                // c0: both set; c1: set at SOC, cleared after; c2: clear at SOC, set after
                hec_err_i = (c == 0) || (c == 1 && b == 1) || (c >= 2 && b > 1);
                pay_err_i = hec_err_i;
                tx_clav_i = b[0]; clav_block_i = b[1];
                apply();
            end
        end
        // directed: a short cell restarted early (R10), then a full cell with HEC flip
        for (int b = 1; b <= 60; b++) begin
            cycle();
            loop_sel_i = 2'b00;
            tx_valid_i = 1; tx_soc_i = (b == 1 || b == 4);
            tx_data_i = 8'hA0 + 8'(b);
            hec_err_i = (b == 4); pay_err_i = 0;
            rx_valid_i = 0;
            apply();
        end
        tx_pos = 0;

        // random phase
        for (int i = 0; i < 8000; i++) begin
            cycle();
            if (i % 97 == 0) loop_sel_i = 2'($urandom);
            if ($urandom_range(0, 40) == 0) hec_err_i = ~hec_err_i;
            if ($urandom_range(0, 40) == 0) pay_err_i = ~pay_err_i;
            tx_clav_i = 1'($urandom); clav_block_i = 1'($urandom);
            gen_tx(1'b1);
            gen_rx();
            apply();
        end
        cycle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule